// File: doc/BRIEF.md
# CSR Access Legality Checker

This block sits beside the instruction decoder of a core with a hypervisor layer. It looks at one decoded control/status register instruction: the 12-bit register address, the kind of operation (swap, set bits, clear bits), whether the source operand is zero and whether the destination is the zero register. It also takes the current privilege mode, the virtualization flag and the register width. From these it decides, in the same cycle, whether the access may read the register, whether it may write it, and which exception to raise if it may not. The result is either no exception, illegal-instruction (cause 2) or virtual-instruction (cause 22).

The required privilege and the read-only property come from the address itself. Bits [11:10] = 11 mark a read-only register, and bits [9:8] give the lowest level that may touch it: 0 user, 1 supervisor, 2 hypervisor/virtual-supervisor, 3 machine. Whether an address names an implemented register comes from the register file, through `i_addr_impl`. Storage, value legalization and counter-enable gating live in other blocks.

Top module: `csr_access_checker`

## Requirements
- R1: When `i_addr_impl` is 0, the access raises cause 2 and neither reads nor writes.
- R2: A write attempt (a swap, or a set/clear with a nonzero operand) to an address with bits [11:10] = 11 raises cause 2.
- R3: A set or clear whose operand is zero (`i_src_zero` = 1) performs no write and raises no read-only fault, but it still reads the register.
- R4: A swap with `i_dst_zero` = 1 performs no read and still writes. A swap with a nonzero destination both reads and writes.
- R5: With `i_virt` = 0, user mode (`i_priv` = 00) reaches level 0, supervisor mode (01) reaches levels 0 to 2, and machine mode (11) reaches every level. Any address above the reachable level raises cause 2.
- R6: Addresses 0x7B0 to 0x7BF raise cause 2 in every mode, including machine mode. Addresses 0x7A0 to 0x7AF are accessible from machine mode.
- R7: With `i_virt` = 1, a level-2 address raises cause 22 from supervisor mode and cause 2 from user mode. A level-1 address raises cause 22 from user mode and is allowed from supervisor mode.
- R8: With `i_virt` = 1, a level-3 address raises cause 2. In machine mode `i_virt` is ignored.
- R9: When `i_xlen_wide` = 1, a high-half address raises cause 2 in every mode. The high-half addresses are 0xC80 to 0xC9F, 0xB80 to 0xB9F, 0x615 and 0x310.
- R10: When `i_xlen_wide` = 0, a high-half address follows the same level rules as its low half. Supervisor mode with `i_virt` = 1 gets cause 22 on 0x615.
- R11: When a fault qualifies for both causes, cause 2 wins. Example: a write from virtual supervisor mode to read-only level-2 address 0xE12 raises cause 2, while a plain read of the same address raises cause 22.
- R12: Operation code 11 and privilege code 10 are reserved and raise cause 2. The operation codes are 00 swap, 01 set and 10 clear.
- R13: The exception output is 0 exactly when the access is legal. A faulting access drives both `o_do_read` and `o_do_write` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_csr_addr | input | 12 | Register address from the instruction |
| i_op | input | 2 | Operation: 00 swap, 01 set, 10 clear, 11 reserved |
| i_src_zero | input | 1 | Source register is x0 or the immediate is zero |
| i_dst_zero | input | 1 | Destination register is x0 |
| i_addr_impl | input | 1 | Address names an implemented register |
| i_priv | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine, 10 reserved |
| i_virt | input | 1 | Virtualization mode flag |
| i_xlen_wide | input | 1 | Register width is greater than 32 |
| o_do_read | output | 1 | Perform the register read |
| o_do_write | output | 1 | Perform the register write |
| o_exc_code | output | 5 | 0 none, 2 illegal-instruction, 22 virtual-instruction |

## Verification
Some properties are checked on every evaluation by the embedded assertions. A faulting access never reads or writes, a read-only register is never written, and the debug window and wide-mode high halves never pass. A zero-operand set/clear never writes, and cause 22 appears only in virtualized modes. Only the directed scenarios can show that the right cause is chosen between the privilege, read-only and virtualization rules. They also show that the priority of cause 2 over cause 22 holds on doubly-faulting accesses, and that the swap-without-destination case suppresses the read.

// File: rtl/csr_chk_pkg.sv
package csr_chk_pkg;
   localparam int CSR_ADDR_W = 12;
   localparam int CAUSE_W    = 5;
   localparam logic [CAUSE_W-1:0] CAUSE_NONE    = 5'd0;
   localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
   localparam logic [CAUSE_W-1:0] CAUSE_VIRT    = 5'd22;

   typedef enum logic [1:0] {
      OP_SWAP  = 2'b00,
      OP_SET   = 2'b01,
      OP_CLEAR = 2'b10,
      OP_RSVD  = 2'b11
   } csr_op_e;

   typedef enum logic [1:0] {
      PRV_U    = 2'b00,
      PRV_S    = 2'b01,
      PRV_RSVD = 2'b10,
      PRV_M    = 2'b11
   } priv_e;

   typedef struct packed {
      logic       ro;
      logic [1:0] lvl;
      logic       dbg_only;
      logic       hi_half;
   } addr_class_t;
endpackage

// File: rtl/csr_addr_class.sv
module csr_addr_class
   import csr_chk_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int N_HI_EXT = 2,
   parameter logic [N_HI_EXT*ADDR_W-1:0] HI_EXT = {12'h615, 12'h310},
   parameter logic [ADDR_W-5:0] DBG_PAGE = 8'h7B
) (
   input  logic [ADDR_W-1:0] addr,
   output addr_class_t       cls
);
   localparam int RO_MSB  = ADDR_W - 1;
   localparam int LVL_MSB = ADDR_W - 3;

   if (ADDR_W != 12) begin : g_bad_w
      $error("csr_addr_class: ADDR_W must be 12");
   end
   if (N_HI_EXT < 1) begin : g_bad_n
      $error("csr_addr_class: N_HI_EXT must be at least 1");
   end

   logic [N_HI_EXT-1:0] ext_hit;
   for (genvar g = 0; g < N_HI_EXT; g++) begin : g_hi_ext
      assign ext_hit[g] = (addr == HI_EXT[g*ADDR_W +: ADDR_W]);
   end

   logic counter_hi;
   always_comb begin
      counter_hi = ((addr[11:8] == 4'hC) || (addr[11:8] == 4'hB))
                   && (addr[7:5] == 3'b100);
   end

   always_comb begin
      cls.ro       = &addr[RO_MSB -: 2];
      cls.lvl      = addr[LVL_MSB -: 2];
      cls.dbg_only = (addr[ADDR_W-1:4] == DBG_PAGE);
      cls.hi_half  = counter_hi | (|ext_hit);
   end
endmodule

// File: rtl/csr_priv_gate.sv
module csr_priv_gate
   import csr_chk_pkg::*;
#(
   parameter bit HAS_HYP = 1'b1
) (
   input  logic [1:0] req_lvl,
   input  logic [1:0] priv,
   input  logic       virt,
   output logic       fail_ill,
   output logic       fail_virt
);
   logic eff_virt;
   assign eff_virt = virt & (priv != PRV_M);

   if (HAS_HYP) begin : g_hyp
      always_comb begin
         fail_ill  = 1'b0;
         fail_virt = 1'b0;
         unique case (priv)
            PRV_M:    ;
            PRV_RSVD: fail_ill = 1'b1;
            PRV_S: begin
               if (!eff_virt) fail_ill = (req_lvl == 2'd3);
               else begin
                  fail_ill  = (req_lvl == 2'd3);
                  fail_virt = (req_lvl == 2'd2);
               end
            end
            default: begin
               if (!eff_virt) fail_ill = (req_lvl != 2'd0);
               else begin
                  fail_ill  = (req_lvl >= 2'd2);
                  fail_virt = (req_lvl == 2'd1);
               end
            end
         endcase
      end
   end else begin : g_nohyp
      always_comb begin
         fail_virt = 1'b0;
         unique case (priv)
            PRV_M:    fail_ill = 1'b0;
            PRV_RSVD: fail_ill = 1'b1;
            PRV_S:    fail_ill = (req_lvl >= 2'd2);
            default:  fail_ill = (req_lvl != 2'd0);
         endcase
      end
   end

   always_comb begin
      // R7
      virt_mode_chk: assert (!(fail_virt && !eff_virt))
         else $error("virtual cause outside virtualized mode");
      // R8
      mach_lvl_chk: assert (!((req_lvl == 2'd3) && (priv != PRV_M) && !fail_ill))
         else $error("machine-level address passed below machine mode");
   end
endmodule

// File: rtl/csr_access_checker.sv
module csr_access_checker
   import csr_chk_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter bit HAS_HYP = 1'b1
) (
   input  logic [11:0] i_csr_addr,
   input  logic [1:0]  i_op,
   input  logic        i_src_zero,
   input  logic        i_dst_zero,
   input  logic        i_addr_impl,
   input  logic [1:0]  i_priv,
   input  logic        i_virt,
   input  logic        i_xlen_wide,
   output logic        o_do_read,
   output logic        o_do_write,
   output logic [4:0]  o_exc_code
);
   if (ADDR_W != CSR_ADDR_W) begin : g_bad_w
      $error("csr_access_checker: ADDR_W must match the package");
   end

   addr_class_t cls;
   logic gate_ill, gate_virt;

   csr_addr_class #(.ADDR_W(ADDR_W)) u_class (
      .addr (i_csr_addr),
      .cls  (cls)
   );

   csr_priv_gate #(.HAS_HYP(HAS_HYP)) u_gate (
      .req_lvl   (cls.lvl),
      .priv      (i_priv),
      .virt      (i_virt),
      .fail_ill  (gate_ill),
      .fail_virt (gate_virt)
   );

   logic is_swap, write_try, read_try, any_ill, any_virt;

   always_comb begin
      is_swap   = (i_op == OP_SWAP);
      write_try = is_swap | ((i_op != OP_RSVD) & !i_src_zero);
      read_try  = !(is_swap & i_dst_zero);
      any_ill   = (i_op == OP_RSVD) | !i_addr_impl | cls.dbg_only
                | (cls.hi_half & i_xlen_wide) | (cls.ro & write_try)
                | gate_ill;
      any_virt  = gate_virt & !any_ill;
      if (any_ill)       o_exc_code = CAUSE_ILLEGAL;
      else if (any_virt) o_exc_code = CAUSE_VIRT;
      else               o_exc_code = CAUSE_NONE;
      o_do_read  = read_try  & !any_ill & !any_virt;
      o_do_write = write_try & !any_ill & !any_virt;
   end

   always_comb begin
      // R13
      fault_quiet_chk: assert (!((o_exc_code != CAUSE_NONE) && (o_do_read || o_do_write)))
         else $error("faulting access still reads or writes");
      // R2
      ro_write_chk: assert (!(o_do_write && cls.ro))
         else $error("write reached a read-only register");
      // R3
      zero_operand_chk: assert (!((i_op != OP_SWAP) && i_src_zero && o_do_write))
         else $error("zero-operand set/clear wrote");
      // R6
      debug_window_chk: assert (!(cls.dbg_only && (o_exc_code != CAUSE_ILLEGAL)))
         else $error("debug-only address accepted");
      // R9
      hi_wide_chk: assert (!(cls.hi_half && i_xlen_wide && (o_exc_code != CAUSE_ILLEGAL)))
         else $error("high-half address accepted in wide mode");
      // R1
      absent_chk: assert (!(!i_addr_impl && (o_exc_code != CAUSE_ILLEGAL)))
         else $error("absent register accepted");
   end
endmodule

// File: tb/csr_access_checker_bench.sv
module csr_access_checker_bench;
   logic        clk = 1'b0;
   logic [11:0] addr;
   logic [1:0]  op, priv;
   logic        src_zero, dst_zero, impl, virt, wide;
   logic        do_read, do_write;
   logic [4:0]  exc;
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   csr_access_checker u_csr_access_checker (
      .i_csr_addr (addr), .i_op (op), .i_src_zero (src_zero),
      .i_dst_zero (dst_zero), .i_addr_impl (impl), .i_priv (priv),
      .i_virt (virt), .i_xlen_wide (wide), .o_do_read (do_read),
      .o_do_write (do_write), .o_exc_code (exc)
   );

   task automatic drive(input logic [11:0] a, input logic [1:0] o, input logic sz,
                        input logic dz, input logic im, input logic [1:0] p,
                        input logic v, input logic w);
      @(negedge clk);
      addr = a; op = o; src_zero = sz; dst_zero = dz;
      impl = im; priv = p; virt = v; wide = w;
      #2;
   endtask

   task automatic expect3(input string req, input logic er, input logic ew,
                          input logic [4:0] ee);
      checks++;
      if (do_read !== er || do_write !== ew || exc !== ee) begin
         errors++;
         $display("FAIL %s addr=%h: got rd=%b wr=%b exc=%0d, expected rd=%b wr=%b exc=%0d",
                  req, addr, do_read, do_write, exc, er, ew, ee);
      end
   endtask

   task automatic t_idle;
      drive(12'h300, 2'b01, 1, 0, 1, 2'b11, 0, 0);
      expect3("R13 idle read", 1, 0, 0);
   endtask

   task automatic t_absent;
      drive(12'h300, 2'b00, 0, 0, 0, 2'b11, 0, 0);
      expect3("R1 absent", 0, 0, 2);
   endtask

   task automatic t_readonly;
      drive(12'hF11, 2'b00, 0, 0, 1, 2'b11, 0, 0); expect3("R2 swap ro", 0, 0, 2);
      drive(12'hF11, 2'b01, 0, 0, 1, 2'b11, 0, 0); expect3("R2 set ro", 0, 0, 2);
      drive(12'hF11, 2'b01, 1, 0, 1, 2'b11, 0, 0); expect3("R3 set zero ro", 1, 0, 0);
      drive(12'hC00, 2'b10, 1, 0, 1, 2'b00, 0, 0); expect3("R3 clear zero ro user", 1, 0, 0);
      drive(12'h340, 2'b10, 0, 0, 1, 2'b11, 0, 0); expect3("R3 clear nonzero", 1, 1, 0);
   endtask

   task automatic t_swap_dst;
      drive(12'h340, 2'b00, 0, 1, 1, 2'b11, 0, 0); expect3("R4 swap x0", 0, 1, 0);
      drive(12'h340, 2'b00, 0, 0, 1, 2'b11, 0, 0); expect3("R4 swap rd", 1, 1, 0);
   endtask

   task automatic t_levels;
      drive(12'h100, 2'b01, 1, 0, 1, 2'b00, 0, 0); expect3("R5 user to S", 0, 0, 2);
      drive(12'h600, 2'b00, 0, 0, 1, 2'b01, 0, 0); expect3("R5 HS to H", 1, 1, 0);
      drive(12'h300, 2'b01, 1, 0, 1, 2'b01, 0, 0); expect3("R5 HS to M", 0, 0, 2);
      drive(12'hC00, 2'b01, 1, 0, 1, 2'b00, 0, 0); expect3("R5 user to U", 1, 0, 0);
   endtask

   task automatic t_debug;
      drive(12'h7B0, 2'b01, 1, 0, 1, 2'b11, 0, 0); expect3("R6 7B0", 0, 0, 2);
      drive(12'h7BF, 2'b00, 0, 0, 1, 2'b11, 0, 0); expect3("R6 7BF", 0, 0, 2);
      drive(12'h7A5, 2'b00, 0, 0, 1, 2'b11, 0, 0); expect3("R6 7A5", 1, 1, 0);
   endtask

   task automatic t_virt;
      drive(12'h200, 2'b00, 0, 0, 1, 2'b01, 1, 0); expect3("R7 VS to VS csr", 0, 0, 22);
      drive(12'h200, 2'b00, 0, 0, 1, 2'b00, 1, 0); expect3("R7 VU to VS csr", 0, 0, 2);
      drive(12'h140, 2'b01, 1, 0, 1, 2'b00, 1, 0); expect3("R7 VU to S csr", 0, 0, 22);
      drive(12'h140, 2'b00, 0, 0, 1, 2'b01, 1, 0); expect3("R7 VS to S csr", 1, 1, 0);
      drive(12'h300, 2'b01, 1, 0, 1, 2'b01, 1, 0); expect3("R8 VS to M csr", 0, 0, 2);
      drive(12'h300, 2'b00, 0, 0, 1, 2'b11, 1, 0); expect3("R8 M ignores V", 1, 1, 0);
   endtask

   task automatic t_hihalf;
      drive(12'hC80, 2'b01, 1, 0, 1, 2'b11, 0, 1); expect3("R9 C80 wide", 0, 0, 2);
      drive(12'h310, 2'b00, 0, 0, 1, 2'b11, 0, 1); expect3("R9 310 wide", 0, 0, 2);
      drive(12'hC80, 2'b01, 1, 0, 1, 2'b11, 0, 0); expect3("R10 C80 narrow", 1, 0, 0);
      drive(12'h615, 2'b01, 1, 0, 1, 2'b01, 1, 0); expect3("R10 VS 615 narrow", 0, 0, 22);
      drive(12'hC80, 2'b01, 1, 0, 1, 2'b01, 1, 0); expect3("R10 VS C80 narrow", 1, 0, 0);
      drive(12'h615, 2'b01, 1, 0, 1, 2'b01, 1, 1); expect3("R9 VS 615 wide", 0, 0, 2);
   endtask

   task automatic t_priority;
      drive(12'hE12, 2'b00, 0, 0, 1, 2'b01, 1, 0); expect3("R11 VS write ro H", 0, 0, 2);
      drive(12'hE12, 2'b01, 1, 0, 1, 2'b01, 1, 0); expect3("R11 VS read ro H", 0, 0, 22);
      drive(12'hD00, 2'b00, 0, 0, 1, 2'b00, 1, 0); expect3("R11 VU write ro S", 0, 0, 2);
   endtask

   task automatic t_reserved;
      drive(12'h300, 2'b11, 0, 0, 1, 2'b11, 0, 0); expect3("R12 op rsvd", 0, 0, 2);
      drive(12'hC00, 2'b01, 1, 0, 1, 2'b10, 0, 0); expect3("R12 priv rsvd", 0, 0, 2);
   endtask

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_idle;
      t_absent;
      t_readonly;
      t_swap_dst;
      t_levels;
      t_debug;
      t_virt;
      t_hihalf;
      t_priority;
      t_reserved;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule